// File: doc/BRIEF.md
# Buffered Parallel-to-Serial Shift Register

This block turns a parallel word into a serial bit stream using two registers, each on its own clock. A holding register takes the parallel input word on the rising edge of a storage clock. A separate shift register can take the holding register's contents, or move its bits one place per rising edge of a shift clock. The last stage of the shift register drives the serial output.

Loading and clearing the shift register are asynchronous, level-sensitive controls. While the active-low load input is low, the shift register follows the holding register with no clock edge needed. While the active-low master reset is low, the shift register is forced to zero. Master reset never touches the holding register. Because of this split, a new word can be captured while the previous word is still being shifted out. It is moved across with a short load pulse.

Top module: `piso_buf_shreg`

## Requirements
- R1: On each rising edge of `stor_clk_i`, the holding register captures `par_data_i`.
- R2: `rst_ni` has no effect on the holding register. A word captured before a reset pulse can still be loaded and shifted out unchanged after the reset is released.
- R3: While `rst_ni` is low, every shift register stage is 0 and `ser_data_o` is 0. This takes effect without any shift clock edge.
- R4: While `load_ni` is low and `rst_ni` is high, the shift register equals the holding register. `ser_data_o` shows holding bit 7 without any shift clock edge.
- R5: While `load_ni` stays low, a new word captured into the holding register reaches the shift register at once.
- R6: When `load_ni` and `rst_ni` are high, each rising edge of `shift_clk_i` moves stage i into stage i+1 and puts `ser_data_i` into stage 0. `ser_data_o` is stage 7. After a load, the word therefore leaves most significant bit first, and serial input bits come out in the order they went in.
- R7: A rising edge of `shift_clk_i` while `load_ni` is low does not shift.
- R8: When `rst_ni` and `load_ni` are both low, reset wins and the shift register is zero. If `rst_ni` is released while `load_ni` is still low, the shift register takes the holding register's value.
- R9: While `load_ni` is high, a capture into the holding register does not change the shift register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| stor_clk_i | input | 1 | Holding register capture clock, rising edge |
| shift_clk_i | input | 1 | Shift register clock, rising edge |
| rst_ni | input | 1 | Asynchronous master clear of the shift register, active low |
| load_ni | input | 1 | Asynchronous transfer from the holding register into the shift register, active low |
| par_data_i | input | DATA_W (8) | Parallel input word |
| ser_data_i | input | 1 | Serial input into stage 0 |
| ser_data_o | output | 1 | Serial output from the last stage |

## Verification
The hardest case to reach is a change on an asynchronous level while the other asynchronous level is still held. Two examples are reset being released while load is still low, and a new holding-register capture while the shift register is transparent to it. To reach these, the stimulus keeps one control low over a whole sequence of events, then checks the serial output between clock edges. The shift register is observed only through the serial port. Every stored value is therefore read back by clocking it out in full, with known serial-input bits following it.

// File: rtl/piso_pkg.sv
`timescale 1ns/1ps
package piso_pkg;
  localparam int unsigned DEF_DATA_W = 8;
endpackage

// File: rtl/piso_hold_reg.sv
`timescale 1ns/1ps
module piso_hold_reg #(
  parameter int unsigned DATA_W = piso_pkg::DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  // no reset: the master clear is for the shift path only
  always_ff @(posedge clk_i) q_o <= d_i;
endmodule

// File: rtl/piso_shift_cell.sv
`timescale 1ns/1ps
module piso_shift_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_ni,
  input  logic hold_i,
  input  logic d_i,
  output logic q_o
);
  logic set_w, clr_w;

  // set gated by reset so reset wins and release re-triggers the set
  assign set_w = rst_ni & ~load_ni & hold_i;
  assign clr_w = ~rst_ni | (~load_ni & ~hold_i);

  always_ff @(posedge clk_i or posedge clr_w or posedge set_w) begin
    if (clr_w)      q_o <= 1'b0;
    else if (set_w) q_o <= 1'b1;
    else            q_o <= d_i;
  end
endmodule

// File: rtl/piso_shift_chain.sv
`timescale 1ns/1ps
module piso_shift_chain #(
  parameter int unsigned DATA_W = piso_pkg::DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_ni,
  input  logic [DATA_W-1:0] hold_i,
  input  logic              ser_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] d_w;

  for (genvar i = 0; i < DATA_W; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign d_w[i] = ser_i;
    end else begin : g_body
      assign d_w[i] = q_o[i-1];
    end
    piso_shift_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_ni(load_ni),
      .hold_i (hold_i[i]),
      .d_i    (d_w[i]),
      .q_o    (q_o[i])
    );
  end

  // R3
  reset_clears_chk: assert property (@(posedge clk_i)
    !rst_ni |-> q_o == '0);

  // R4
  load_follows_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |-> q_o == hold_i);

  // R6
  shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && $past(load_ni) && $past(rst_ni))
      |-> q_o == {$past(q_o[DATA_W-2:0]), $past(ser_i)});
endmodule

// File: rtl/piso_buf_shreg.sv
`timescale 1ns/1ps
module piso_buf_shreg #(
  parameter int unsigned DATA_W = piso_pkg::DEF_DATA_W
) (
  input  logic              stor_clk_i,
  input  logic              shift_clk_i,
  input  logic              rst_ni,
  input  logic              load_ni,
  input  logic [DATA_W-1:0] par_data_i,
  input  logic              ser_data_i,
  output logic              ser_data_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] chain_q;

  piso_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk_i(stor_clk_i),
    .d_i  (par_data_i),
    .q_o  (hold_q)
  );

  piso_shift_chain #(.DATA_W(DATA_W)) u_chain (
    .clk_i  (shift_clk_i),
    .rst_ni (rst_ni),
    .load_ni(load_ni),
    .hold_i (hold_q),
    .ser_i  (ser_data_i),
    .q_o    (chain_q)
  );

  assign ser_data_o = chain_q[MSB];

  // R6
  ser_out_order_chk: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
    (load_ni && $past(load_ni) && $past(rst_ni)) |-> ser_data_o == $past(chain_q[MSB-1]));
endmodule

// File: tb/tb_piso_buf_shreg.sv
`timescale 1ns/1ps
module tb_piso_buf_shreg;
  localparam int W = 8;
  localparam int NV = 6;
  // {parallel word, serial-in pattern}, pattern bit k enters on shift k
  localparam logic [15:0] VEC [NV] = '{16'hA5_3C, 16'h00_FF, 16'hFF_00,
                                       16'h81_5A, 16'h7E_C3, 16'h01_80};

  logic stor_clk = 0, shift_clk = 0, rst_n = 1, load_n = 1, ser_i = 0;
  logic [W-1:0] par = '0;
  logic ser_o;
  int checks = 0, errors = 0;
  bit done = 0;

  piso_buf_shreg #(.DATA_W(W)) dut (
    .stor_clk_i(stor_clk), .shift_clk_i(shift_clk), .rst_ni(rst_n),
    .load_ni(load_n), .par_data_i(par), .ser_data_i(ser_i), .ser_data_o(ser_o)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ser_data_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic store(input logic [W-1:0] v);
    par = v; #2 stor_clk = 1; #10 stor_clk = 0; #8;
  endtask

  task automatic shift(input logic b);
    ser_i = b; #2 shift_clk = 1; #10 shift_clk = 0; #8;
  endtask

  // load with a shift edge while held low
  task automatic load_word(input logic [W-1:0] v, input string req);
    load_n = 0; #2;
    check(ser_o, v[W-1], req);
    shift(~v[W-1]);
    check(ser_o, v[W-1], "R7");
    load_n = 1; #2;
  endtask

  task automatic reset_pulse();
    rst_n = 0; #2;
    check(ser_o, 1'b0, "R3");
    shift(1'b1);
    rst_n = 1; #2;
  endtask

  task automatic read_word(input logic [W-1:0] v, input string req);
    for (int k = 0; k < W; k++) begin
      check(ser_o, v[W-1-k], req);
      shift(1'b0);
    end
  endtask

  initial begin
    #1 rst_n = 0; #3;
    check(ser_o, 1'b0, "R3");
    shift(1'b1);
    check(ser_o, 1'b0, "R3");
    rst_n = 1; #4;

    // table: store, load, shift word out, then serial-in pattern
    for (int v = 0; v < NV; v++) begin
      logic [W-1:0] d, p;
      d = VEC[v][15:8]; p = VEC[v][7:0];
      store(d);
      load_word(d, "R1");
      for (int k = 0; k < W; k++) begin
        check(ser_o, d[W-1-k], "R6");
        shift(p[k]);
      end
      for (int k = 0; k < W; k++) begin
        check(ser_o, p[k], "R6");
        shift(1'b0);
      end
    end

    // R2: holding register survives reset
    store(8'hC6);
    reset_pulse();
    load_word(8'hC6, "R2");
    read_word(8'hC6, "R2");

    // R3: clear mid-word
    store(8'hFF);
    load_word(8'hFF, "R4");
    shift(1'b1);
    reset_pulse();
    read_word(8'h00, "R3");

    // R5: transparent while load held low
    store(8'h12);
    load_n = 0; #2;
    check(ser_o, 1'b0, "R5");
    store(8'h93);
    check(ser_o, 1'b1, "R5");
    shift(1'b0);
    load_n = 1; #2;
    read_word(8'h93, "R5");

    // R8: reset beats load, release while load low
    store(8'hB7);
    rst_n = 0; load_n = 0; #2;
    check(ser_o, 1'b0, "R8");
    shift(1'b1);
    check(ser_o, 1'b0, "R8");
    rst_n = 1; #2;
    check(ser_o, 1'b1, "R8");
    shift(1'b0);
    load_n = 1; #2;
    read_word(8'hB7, "R8");

    // R9: capture with load high leaves shift register alone
    store(8'h6D);
    load_word(8'h6D, "R4");
    store(8'h92);
    read_word(8'h6D, "R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule